// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt message into the set of processor slots that should receive it. A table holds one entry per slot: an 8-bit physical ID, an 8-bit logical ID, a 4-bit logical model (flat or cluster) and a present flag. A configuration port writes the table.

A message carries these fields:
- an 8-bit destination;
- a logical/physical select bit;
- a 2-bit shorthand;
- a 3-bit delivery mode;
- level and trigger bits;
- the index of the sending slot.

The block resolves the message to a target bitmask with one bit per slot. It then applies the delivery-mode rules. Lowest-priority delivery keeps only one target. A de-assert INIT message reloads the arbitration IDs of its targets and delivers nothing. The arbitration ID of any slot can be read back through a read-select port.

The control is a three-state machine:
- **IDLE** shows `msg_ready`. A message that arrives here is captured (transition IDLE→RESOLVE).
- **RESOLVE** computes the raw target mask from the captured message and the table, and registers it (RESOLVE→DONE).
- **DONE** presents `out_valid` and `out_mask` for exactly one cycle. It performs any arbitration-ID reload and returns to IDLE (DONE→IDLE).

Top module: `intr_dest_resolver`

## Requirements
- R1: Shorthand 1 targets only the slot named by `msg_sender`. A sender index outside the table targets nothing.
- R2: Shorthand 2 targets every present slot, the sender included.
- R3: Shorthand 3 targets every present slot except the sender.
- R4: With shorthand 0 and `msg_logical`=0, destination 0xFF targets every present slot.
- R5: With shorthand 0 and `msg_logical`=0, any other destination targets the single present slot whose physical ID equals it. If several slots match, the lowest-indexed one is chosen. If none matches, the mask is empty.
- R6: With shorthand 0 and `msg_logical`=1, a present slot with model 4'hF matches when destination AND logical ID is nonzero.
- R7: With shorthand 0 and `msg_logical`=1, a present slot with model 4'h0 matches when destination[7:4] equals logical ID[7:4] and destination[3:0] AND logical ID[3:0] is nonzero.
- R8: A slot whose model is neither 4'h0 nor 4'hF never matches a logical destination.
- R9: A slot whose present flag is 0 is never set in `out_mask`, under any shorthand or mode.
- R10: Delivery mode 1 (lowest priority) outputs only the lowest-indexed bit of the target mask.
- R11: Delivery mode 5 with level 0 and trigger 1 outputs an all-zero mask. In the same cycle, each targeted slot's arbitration ID is loaded from its physical ID. Other slots' arbitration IDs are unchanged.
- R12: Delivery mode 3 is reserved and outputs an all-zero mask. Modes 0, 2, 4, 6 and 7, and mode 5 with level 1 or trigger 0, output the target mask unchanged.
- R13: A message accepted while `msg_ready`=1 produces `out_valid` exactly two cycles later, for one cycle. `msg_valid` is ignored while `msg_ready`=0.
- R14: After reset, `out_valid`=0, `msg_ready`=1, and every arbitration ID reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | SLOT_W | Slot index written |
| cfg_phys_id | input | 8 | Physical ID to store |
| cfg_log_id | input | 8 | Logical ID to store |
| cfg_model | input | 4 | Logical model (4'hF flat, 4'h0 cluster) |
| cfg_present | input | 1 | Present flag to store |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Resolver idle and able to accept |
| msg_dest | input | 8 | Destination field |
| msg_logical | input | 1 | 1 = logical destination, 0 = physical |
| msg_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| msg_dmode | input | 3 | Delivery mode code |
| msg_level | input | 1 | Level bit |
| msg_trigger | input | 1 | Trigger bit |
| msg_sender | input | SLOT_W | Sending slot index |
| out_valid | output | 1 | Result pulse |
| out_mask | output | N | Target slots |
| rd_slot | input | SLOT_W | Arbitration-ID read select |
| rd_arb_id | output | 8 | Arbitration ID of the selected slot |

## Verification
The table is loaded so that each case exercises a distinct matching rule:
- several flat logical IDs;
- two cluster entries in the same cluster with different member bits;
- a slot with an invalid model;
- two slots that share a physical ID;
- an absent slot that would otherwise match everything.

Physical destinations (broadcast, unique hit, duplicate hit, absent-only hit and miss) separate exact-ID matching from the lowest-slot tie-break and from the present filter. Logical destinations are chosen to match only flat entries, only one cluster member, or both cluster members plus flat entries, which tells the two models apart. All four shorthands are also driven, including a sender that is absent. Every delivery code is run over the same broadcast, and two de-assert INIT messages change the arbitration IDs visibly. A message held on the input while the resolver is busy confirms that it yields a single result.

// File: rtl/intr_dest_pkg.sv
package intr_dest_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RESOLVE = 2'd1,
        S_DONE    = 2'd2
    } rstate_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] PHYS_BCAST    = 8'hFF;

    typedef struct packed {
        logic [7:0] dest;
        logic       logical;
        shorthand_e sh;
        dmode_e     dm;
        logic       level;
        logic       trigger;
    } msg_t;

endpackage

// File: rtl/idr_lowest_pick.sv
module idr_lowest_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);
    // two's-complement isolate of the least significant set bit
    always_comb vec_out = vec_in & (~vec_in + W'(1));
endmodule

// File: rtl/idr_slot_table.sv
module idr_slot_table #(
    parameter int N      = 8,
    parameter int SLOT_W = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SLOT_W-1:0]     cfg_slot,
    input  logic [7:0]            cfg_phys_id,
    input  logic [7:0]            cfg_log_id,
    input  logic [3:0]            cfg_model,
    input  logic                  cfg_present,
    input  logic [N-1:0]          arb_load,
    input  logic [SLOT_W-1:0]     rd_slot,
    output logic [N-1:0][7:0]     phys_ids,
    output logic [N-1:0][7:0]     log_ids,
    output logic [N-1:0][3:0]     models,
    output logic [N-1:0]          present,
    output logic [7:0]            rd_arb_id
);
    logic [N-1:0][7:0] arb_ids;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit;
        assign hit = cfg_we && (cfg_slot == SLOT_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                phys_ids[i] <= 8'h00;
                log_ids[i]  <= 8'h00;
                models[i]   <= intr_dest_pkg::MODEL_FLAT;
                present[i]  <= 1'b0;
            end else if (hit) begin
                phys_ids[i] <= cfg_phys_id;
                log_ids[i]  <= cfg_log_id;
                models[i]   <= cfg_model;
                present[i]  <= cfg_present;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           arb_ids[i] <= 8'h00;
            else if (arb_load[i]) arb_ids[i] <= phys_ids[i];
        end
    end

    always_comb begin
        rd_arb_id = 8'h00;
        for (int i = 0; i < N; i++)
            if (rd_slot == SLOT_W'(i)) rd_arb_id = arb_ids[i];
    end
endmodule

// File: rtl/idr_match.sv
module idr_match
    import intr_dest_pkg::*;
#(
    parameter int N      = 8,
    parameter int SLOT_W = $clog2(N)
) (
    input  msg_t                 msg,
    input  logic [SLOT_W-1:0]    sender,
    input  logic [N-1:0][7:0]    phys_ids,
    input  logic [N-1:0][7:0]    log_ids,
    input  logic [N-1:0][3:0]    models,
    input  logic [N-1:0]         present,
    output logic [N-1:0]         raw_mask
);
    logic [N-1:0] self_vec;
    logic [N-1:0] phys_eq;
    logic [N-1:0] phys_one;
    logic [N-1:0] log_hit;
    logic [N-1:0] field_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic flat_hit, clus_hit;
        assign self_vec[i] = (sender == SLOT_W'(i));
        assign phys_eq[i]  = present[i] && (phys_ids[i] == msg.dest);
        assign flat_hit    = (models[i] == MODEL_FLAT) && ((msg.dest & log_ids[i]) != 8'h00);
        assign clus_hit    = (models[i] == MODEL_CLUSTER)
                             && (msg.dest[7:4] == log_ids[i][7:4])
                             && ((msg.dest[3:0] & log_ids[i][3:0]) != 4'h0);
        assign log_hit[i]  = flat_hit || clus_hit;
    end

    // duplicate physical IDs resolve to the lowest slot
    idr_lowest_pick #(.W(N)) u_phys_pick (
        .vec_in  (phys_eq),
        .vec_out (phys_one)
    );

    always_comb begin
        if (msg.logical)                 field_vec = log_hit;
        else if (msg.dest == PHYS_BCAST) field_vec = '1;
        else                             field_vec = phys_one;
    end

    always_comb begin
        unique case (msg.sh)
            SH_FIELD:  raw_mask = field_vec & present;
            SH_SELF:   raw_mask = self_vec & present;
            SH_ALL:    raw_mask = present;
            SH_OTHERS: raw_mask = ~self_vec & present;
            default:   raw_mask = '0;
        endcase
    end
endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
    import intr_dest_pkg::*;
#(
    parameter int N      = 8,
    parameter int SLOT_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [7:0]        cfg_phys_id,
    input  logic [7:0]        cfg_log_id,
    input  logic [3:0]        cfg_model,
    input  logic              cfg_present,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [7:0]        msg_dest,
    input  logic              msg_logical,
    input  logic [1:0]        msg_shorthand,
    input  logic [2:0]        msg_dmode,
    input  logic              msg_level,
    input  logic              msg_trigger,
    input  logic [SLOT_W-1:0] msg_sender,
    output logic              out_valid,
    output logic [N-1:0]      out_mask,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [7:0]        rd_arb_id
);
    rstate_e           state, state_nx;
    msg_t              cap_msg;
    logic [SLOT_W-1:0] cap_sender;
    logic [N-1:0]      raw_mask;
    logic [N-1:0]      tgt_q;
    logic [N-1:0]      low_one;
    logic [N-1:0]      arb_load;
    logic              init_deassert;

    logic [N-1:0][7:0] phys_ids;
    logic [N-1:0][7:0] log_ids;
    logic [N-1:0][3:0] models;
    logic [N-1:0]      present;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (msg_valid) state_nx = S_RESOLVE;
            S_RESOLVE: state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_msg    <= '0;
            cap_sender <= '0;
        end else if (state == S_IDLE && msg_valid) begin
            cap_msg.dest    <= msg_dest;
            cap_msg.logical <= msg_logical;
            cap_msg.sh      <= shorthand_e'(msg_shorthand);
            cap_msg.dm      <= dmode_e'(msg_dmode);
            cap_msg.level   <= msg_level;
            cap_msg.trigger <= msg_trigger;
            cap_sender      <= msg_sender;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tgt_q <= '0;
        else if (state == S_RESOLVE) tgt_q <= raw_mask;
    end

    idr_match #(.N(N), .SLOT_W(SLOT_W)) u_match (
        .msg      (cap_msg),
        .sender   (cap_sender),
        .phys_ids (phys_ids),
        .log_ids  (log_ids),
        .models   (models),
        .present  (present),
        .raw_mask (raw_mask)
    );

    idr_lowest_pick #(.W(N)) u_low_pick (
        .vec_in  (tgt_q),
        .vec_out (low_one)
    );

    assign init_deassert = (cap_msg.dm == DM_INIT) && !cap_msg.level && cap_msg.trigger;
    assign arb_load      = (state == S_DONE && init_deassert) ? tgt_q : '0;

    idr_slot_table #(.N(N), .SLOT_W(SLOT_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_slot    (cfg_slot),
        .cfg_phys_id (cfg_phys_id),
        .cfg_log_id  (cfg_log_id),
        .cfg_model   (cfg_model),
        .cfg_present (cfg_present),
        .arb_load    (arb_load),
        .rd_slot     (rd_slot),
        .phys_ids    (phys_ids),
        .log_ids     (log_ids),
        .models      (models),
        .present     (present),
        .rd_arb_id   (rd_arb_id)
    );

    always_comb begin
        msg_ready = (state == S_IDLE);
        out_valid = (state == S_DONE);
        out_mask  = '0;
        if (state == S_DONE) begin
            if (cap_msg.dm == DM_RSVD || init_deassert) out_mask = '0;
            else if (cap_msg.dm == DM_LOWEST)          out_mask = low_one;
            else                                       out_mask = tgt_q;
        end
    end
endmodule

// File: rtl/intr_dest_resolver_chk.sv
module intr_dest_resolver_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         msg_valid,
    input logic         msg_ready,
    input logic         out_valid,
    input logic [N-1:0] out_mask,
    input logic [N-1:0] present,
    input logic [2:0]   dm,
    input logic         lvl,
    input logic         trig
);
    a_r9_present_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~present) == '0));

    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dm == 3'd1) |-> $onehot0(out_mask));

    a_r11_init_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dm == 3'd5 && !lvl && trig) |-> (out_mask == '0));

    a_r12_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dm == 3'd3) |-> (out_mask == '0));

    a_r13_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |-> ##2 out_valid);

    a_r13_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !msg_ready);
endmodule

bind intr_dest_resolver intr_dest_resolver_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .present   (present),
    .dm        (cap_msg.dm),
    .lvl       (cap_msg.level),
    .trig      (cap_msg.trigger)
);

// File: tb/intr_dest_resolver_tb.sv
`timescale 1ns/1ps
module intr_dest_resolver_tb;
    localparam int N  = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cfg_we = 0;
    logic [SW-1:0] cfg_slot = 0;
    logic [7:0]    cfg_phys_id = 0, cfg_log_id = 0;
    logic [3:0]    cfg_model = 0;
    logic          cfg_present = 0;
    logic          msg_valid = 0, msg_ready;
    logic [7:0]    msg_dest = 0;
    logic          msg_logical = 0;
    logic [1:0]    msg_shorthand = 0;
    logic [2:0]    msg_dmode = 0;
    logic          msg_level = 0, msg_trigger = 0;
    logic [SW-1:0] msg_sender = 0;
    logic          out_valid;
    logic [N-1:0]  out_mask;
    logic [SW-1:0] rd_slot = 0;
    logic [7:0]    rd_arb_id;

    intr_dest_resolver #(.N(N), .SLOT_W(SW)) u_dut (.*);

    int vectors = 0, miscompares = 0;
    bit done = 0, mon_on = 0;
    string cur_req = "R14";
    logic exp_v = 0;
    logic [N-1:0] exp_m = '0;

    logic [7:0] m_phys [N];
    logic [7:0] m_log  [N];
    logic [3:0] m_model[N];
    logic       m_pres [N];
    logic [7:0] m_arb  [N];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model's expected output
    initial forever begin
        @(negedge clk); #1;
        if (mon_on) begin
            check({cur_req, " valid"}, 32'(out_valid), 32'(exp_v));
            if (exp_v) check({cur_req, " mask"}, 32'(out_mask), 32'(exp_m));
        end
    end

    function automatic logic [N-1:0] targets(logic [7:0] d, logic lg, logic [1:0] sh, int snd);
        logic [N-1:0] m = '0;
        bit found = 0;
        for (int i = 0; i < N; i++) begin
            case (sh)
                2'd0: begin
                    if (lg) begin
                        if (m_model[i] == 4'hF && (d & m_log[i]) != 0) m[i] = 1;
                        if (m_model[i] == 4'h0 && d[7:4] == m_log[i][7:4]
                            && (d[3:0] & m_log[i][3:0]) != 0) m[i] = 1;
                    end else if (d == 8'hFF) m[i] = 1;
                    else if (!found && m_pres[i] && m_phys[i] == d) begin
                        m[i] = 1; found = 1;
                    end
                end
                2'd1: m[i] = (i == snd);
                2'd2: m[i] = 1;
                default: m[i] = (i != snd);
            endcase
            if (!m_pres[i]) m[i] = 0;
        end
        return m;
    endfunction

    task automatic cfg(int s, logic [7:0] p, logic [7:0] l, logic [3:0] md, logic pr);
        @(negedge clk);
        cfg_we = 1; cfg_slot = SW'(s); cfg_phys_id = p; cfg_log_id = l;
        cfg_model = md; cfg_present = pr;
        @(negedge clk);
        cfg_we = 0;
        m_phys[s] = p; m_log[s] = l; m_model[s] = md; m_pres[s] = pr;
    endtask

    task automatic run(string req, logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm,
                       logic lv, logic tg, int snd, logic [N-1:0] lit, bit hold);
        logic [N-1:0] t, em;
        t = targets(d, lg, sh, snd);
        em = t;
        if (dm == 3'd3 || (dm == 3'd5 && !lv && tg)) em = '0;
        else if (dm == 3'd1) em = t & (~t + 1'b1);
        @(negedge clk);
        cur_req = req;
        msg_valid = 1; msg_dest = d; msg_logical = lg; msg_shorthand = sh;
        msg_dmode = dm; msg_level = lv; msg_trigger = tg; msg_sender = SW'(snd);
        @(negedge clk);
        if (!hold) msg_valid = 0;
        @(negedge clk);
        msg_valid = 0;
        exp_v = 1; exp_m = em;
        #2 check(req, 32'(out_mask), 32'(lit));
        @(negedge clk);
        exp_v = 0;
        if (dm == 3'd5 && !lv && tg)
            for (int i = 0; i < N; i++) if (t[i]) m_arb[i] = m_phys[i];
    endtask

    task automatic arb_check(string req, int s, logic [7:0] lit);
        @(negedge clk);
        rd_slot = SW'(s);
        #2;
        check(req, 32'(rd_arb_id), 32'(m_arb[s]));
        check(req, 32'(rd_arb_id), 32'(lit));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_phys[i] = 0; m_log[i] = 0; m_model[i] = 4'hF; m_pres[i] = 0; m_arb[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R14 reset state
        check("R14 valid", 32'(out_valid), 0);
        check("R14 ready", 32'(msg_ready), 1);
        for (int i = 0; i < N; i++) arb_check("R14 arb", i, 8'h00);
        mon_on = 1;

        cfg(0, 8'h10, 8'h01, 4'hF, 1);
        cfg(1, 8'h11, 8'h02, 4'hF, 1);
        cfg(2, 8'h12, 8'h04, 4'hF, 1);
        cfg(3, 8'h13, 8'h21, 4'h0, 1);
        cfg(4, 8'h14, 8'h32, 4'h0, 1);
        cfg(5, 8'h13, 8'h24, 4'h0, 1);
        cfg(6, 8'h16, 8'hFF, 4'h5, 1);
        cfg(7, 8'h20, 8'hFF, 4'hF, 0);

        run("R4 R9 phys broadcast", 8'hFF, 0, 0, 0, 0, 0, 0, 8'h7F, 0);
        run("R5 phys unique",       8'h12, 0, 0, 0, 0, 0, 0, 8'h04, 0);
        run("R5 phys duplicate",    8'h13, 0, 0, 0, 0, 0, 0, 8'h08, 0);
        run("R9 phys absent slot",  8'h20, 0, 0, 0, 0, 0, 0, 8'h00, 0);
        run("R5 phys miss",         8'h55, 0, 0, 0, 0, 0, 0, 8'h00, 0);
        run("R6 R8 flat only",      8'h03, 1, 0, 0, 0, 0, 0, 8'h03, 0);
        run("R8 bad model",         8'hFF, 1, 0, 0, 0, 0, 0, 8'h07, 0);
        run("R7 cluster one",       8'h21, 1, 0, 0, 0, 0, 0, 8'h09, 0);
        run("R7 cluster two",       8'h25, 1, 0, 0, 0, 0, 0, 8'h2D, 0);
        run("R1 self",              8'h00, 0, 1, 0, 0, 0, 4, 8'h10, 0);
        run("R1 R9 self absent",    8'h00, 0, 1, 0, 0, 0, 7, 8'h00, 0);
        run("R2 all",               8'h00, 0, 2, 0, 0, 0, 2, 8'h7F, 0);
        run("R3 others",            8'h00, 0, 3, 0, 0, 0, 2, 8'h7B, 0);
        run("R10 lowest others",    8'h00, 0, 3, 1, 0, 0, 0, 8'h02, 0);
        run("R10 lowest logical",   8'h25, 1, 0, 1, 0, 0, 0, 8'h01, 0);
        run("R12 mode2",            8'h00, 0, 2, 2, 0, 0, 0, 8'h7F, 0);
        run("R12 mode4",            8'h00, 0, 2, 4, 0, 0, 0, 8'h7F, 0);
        run("R12 mode6",            8'h00, 0, 2, 6, 0, 0, 0, 8'h7F, 0);
        run("R12 mode7",            8'h00, 0, 2, 7, 0, 0, 0, 8'h7F, 0);
        run("R12 reserved",         8'h00, 0, 2, 3, 0, 0, 0, 8'h00, 0);
        run("R12 init assert",      8'h00, 0, 2, 5, 1, 0, 0, 8'h7F, 0);
        for (int i = 0; i < N; i++) arb_check("R11 arb untouched", i, 8'h00);
        run("R11 init deassert",    8'h21, 1, 0, 5, 0, 1, 0, 8'h00, 0);
        arb_check("R11 arb slot0", 0, 8'h10);
        arb_check("R11 arb slot3", 3, 8'h13);
        arb_check("R11 arb slot1", 1, 8'h00);
        arb_check("R11 arb slot5", 5, 8'h00);
        cfg(3, 8'h40, 8'h21, 4'h0, 1);
        run("R11 init self",        8'h00, 0, 1, 5, 0, 1, 3, 8'h00, 0);
        arb_check("R11 arb reload", 3, 8'h40);
        arb_check("R11 arb kept",   0, 8'h10);
        run("R13 held input",       8'h11, 0, 0, 0, 0, 0, 0, 8'h02, 1);
        @(negedge clk); #1;
        check("R13 idle after", 32'(out_valid), 0);
        check("R13 ready after", 32'(msg_ready), 1);

        mon_on = 0;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule